// File: doc/BRIEF.md
# Multithreaded In-Order Issue Scheduler

This block is the issue stage of a core running in a throughput mode. In this mode up to eight hardware threads execute in order and share one select port. Decoded instructions arrive one per cycle. Each carries a thread number, two architectural source registers, one architectural destination register and a tag. Each instruction goes into a small FIFO that belongs to its thread. Only the oldest entry of each thread's FIFO is allowed to leave. Each cycle, one of the eligible heads is chosen and sent out on the issue port.

There is no renaming. The register-file index of every operand is the thread number placed above the architectural register number, which gives one private bank of registers per thread. A ready bit per physical register is cleared when a writer of that register issues. It is set again when the writer's result comes back on the writeback port, a fixed number of cycles later. That port stands in for the execution pipeline. A consumer may issue in the same cycle the result is written, taking the value from a forwarding path. The issue port flags each source that uses this path.

Top module: `smt_inorder_sched`

## Requirements
- R1: Out of reset, `iss_valid` and `wb_valid` are 0 and every bit of `in_ready` is 1.
- R2: An instruction is accepted at a clock edge when `in_valid` is 1 and `in_ready[in_tid]` is 1. `in_ready[t]` is 0 exactly when thread t's FIFO holds DEPTH entries, and a full thread leaves the `in_ready` bits of all other threads at 1.
- R3: Within one thread, instructions appear on the issue port in the order they were accepted, and every accepted instruction eventually issues.
- R4: Each physical index is `{tid, areg}`, with the thread number in the upper TID_W bits and the architectural register in the lower AREG_W bits. This applies to `iss_psrc1`, `iss_psrc2` and `iss_pdst`.
- R5: No instruction issues while one of its source registers has a writer that has issued and has not yet been written back.
- R6: For every instruction shown on the issue port in cycle c, `wb_valid` is 1 with `wb_pdst` equal to its `iss_pdst` in cycle c+WB_LAT, and in no other cycle.
- R7: A consumer whose source is written back in cycle w may appear on the issue port in cycle w+1, with `iss_byp1`/`iss_byp2` set for that source. An unobstructed dependent therefore appears exactly WB_LAT+1 cycles after its producer.
- R8: At most one instruction issues per cycle. When several heads are eligible, the thread chosen is the first eligible one at or after the thread numbered one above the last thread that issued, counting upward with wrap-around.
- R9: An instruction whose destination still has an outstanding writer waits. It may appear no earlier than WB_LAT+1 cycles after that writer, and its bypass flags stay 0 when its sources are already ready.
- R10: An instruction accepted into an empty FIFO, with all its registers ready and no competing thread, appears on the issue port two cycles after the cycle in which it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_tid | input | TID_W | Thread of the presented instruction |
| in_src1 | input | AREG_W | First architectural source |
| in_src2 | input | AREG_W | Second architectural source |
| in_dst | input | AREG_W | Architectural destination |
| in_tag | input | TAG_W | Opaque tag carried to the issue port |
| in_ready | output | NTHR | Per-thread room in the queue |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_tid | output | TID_W | Thread of the issued instruction |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| iss_psrc1 | output | TID_W+AREG_W | Physical first source |
| iss_psrc2 | output | TID_W+AREG_W | Physical second source |
| iss_pdst | output | TID_W+AREG_W | Physical destination |
| iss_byp1 | output | 1 | First source is taken from the forwarding path |
| iss_byp2 | output | 1 | Second source is taken from the forwarding path |
| wb_valid | output | 1 | A result is written this cycle |
| wb_pdst | output | TID_W+AREG_W | Physical register written |

## Verification
The hardest case to reach is two threads becoming eligible in the same cycle, because only one instruction enters per cycle and an idle thread issues at once. The stimulus gives two threads each a producer and a dependent consumer. It places an independent instruction behind the first consumer, so that this younger instruction and the second thread's consumer unblock on the same edge. The resulting issue order tells rotating selection apart from fixed priority. A queue is filled by a chain of self-dependent instructions, each stalled for the full writeback latency, so the full state and its effect on other threads can be seen.

// File: rtl/smt_sched_pkg.sv
package smt_sched_pkg;
  localparam int unsigned DEF_THREADS = 8;
  localparam int unsigned DEF_AREGS   = 16;
  localparam int unsigned DEF_DEPTH   = 4;
  localparam int unsigned DEF_WB_LAT  = 3;
  localparam int unsigned DEF_TAG_W   = 8;
endpackage

// File: rtl/isq_thread_fifo.sv
module isq_thread_fifo #(
  parameter int unsigned WIDTH = 20,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             not_empty,
  output logic             has_room
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign has_room  = (cnt_q != CNT_W'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign push_ok   = push && has_room;
  assign pop_ok    = pop && not_empty;
  assign rd_data   = slot[rd_q];

  always_comb begin
    wr_d  = push_ok ? bump(wr_q) : wr_q;
    rd_d  = pop_ok  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + CNT_W'(1);
    if (pop_ok && !push_ok) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slot[wr_q] <= wr_data;
  end
endmodule

// File: rtl/isq_ready_board.sv
module isq_ready_board #(
  parameter int unsigned NPREG  = 128,
  parameter int unsigned PREG_W = 7,
  parameter int unsigned WB_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [PREG_W-1:0] clr_idx,
  input  logic              res_v,
  input  logic [PREG_W-1:0] res_idx,
  output logic [NPREG-1:0]  rdy,
  output logic              wb_valid,
  output logic [PREG_W-1:0] wb_idx
);
  logic [NPREG-1:0]  rdy_q, rdy_d;
  logic [WB_LAT-1:0] pv_q, pv_d;
  logic [PREG_W-1:0] pi_q [WB_LAT];
  logic [PREG_W-1:0] pi_d [WB_LAT];

  assign rdy      = rdy_q;
  assign wb_valid = pv_q[WB_LAT-1];
  assign wb_idx   = pi_q[WB_LAT-1];

  always_comb begin
    pv_d[0] = res_v;
    pi_d[0] = res_idx;
    for (int s = 1; s < int'(WB_LAT); s++) begin
      pv_d[s] = pv_q[s-1];
      pi_d[s] = pi_q[s-1];
    end
  end

  always_comb begin
    rdy_d = rdy_q;
    if (wb_valid) rdy_d[wb_idx] = 1'b1;
    if (clr_en)   rdy_d[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '1;
      pv_q  <= '0;
      for (int s = 0; s < int'(WB_LAT); s++) pi_q[s] <= '0;
    end else begin
      rdy_q <= rdy_d;
      pv_q  <= pv_d;
      for (int s = 0; s < int'(WB_LAT); s++) pi_q[s] <= pi_d[s];
    end
  end
endmodule

// File: rtl/isq_rr_pick.sv
module isq_rr_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             gnt_v,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    logic [IDX_W-1:0] cand;
    gnt_v   = 1'b0;
    gnt_idx = ptr_q;
    for (int k = 0; k < int'(N); k++) begin
      cand = ptr_q + IDX_W'(k);
      if (!gnt_v && req[cand]) begin
        gnt_v   = 1'b1;
        gnt_idx = cand;
      end
    end
    ptr_d = gnt_v ? gnt_idx + IDX_W'(1) : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/smt_inorder_sched.sv
module smt_inorder_sched
  import smt_sched_pkg::*;
#(
  parameter int unsigned NTHR   = DEF_THREADS,
  parameter int unsigned NAREG  = DEF_AREGS,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned WB_LAT = DEF_WB_LAT,
  parameter int unsigned TAG_W  = DEF_TAG_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [$clog2(NTHR)-1:0]               in_tid,
  input  logic [$clog2(NAREG)-1:0]              in_src1,
  input  logic [$clog2(NAREG)-1:0]              in_src2,
  input  logic [$clog2(NAREG)-1:0]              in_dst,
  input  logic [TAG_W-1:0]                      in_tag,
  output logic [NTHR-1:0]                       in_ready,
  output logic                                  iss_valid,
  output logic [$clog2(NTHR)-1:0]               iss_tid,
  output logic [TAG_W-1:0]                      iss_tag,
  output logic [$clog2(NTHR)+$clog2(NAREG)-1:0] iss_psrc1,
  output logic [$clog2(NTHR)+$clog2(NAREG)-1:0] iss_psrc2,
  output logic [$clog2(NTHR)+$clog2(NAREG)-1:0] iss_pdst,
  output logic                                  iss_byp1,
  output logic                                  iss_byp2,
  output logic                                  wb_valid,
  output logic [$clog2(NTHR)+$clog2(NAREG)-1:0] wb_pdst
);
  localparam int unsigned TID_W  = $clog2(NTHR);
  localparam int unsigned AREG_W = $clog2(NAREG);
  localparam int unsigned PREG_W = TID_W + AREG_W;
  localparam int unsigned NPREG  = NTHR * NAREG;
  localparam int unsigned ENT_W  = 3 * AREG_W + TAG_W;

  logic [NPREG-1:0]  rdy;
  logic              wb_v;
  logic [PREG_W-1:0] wb_i;

  logic [NTHR-1:0]   push, pop, head_v, elig;
  logic [ENT_W-1:0]  head_ent [NTHR];
  logic [PREG_W-1:0] h_ps1 [NTHR];
  logic [PREG_W-1:0] h_ps2 [NTHR];
  logic [PREG_W-1:0] h_pd  [NTHR];
  logic [TAG_W-1:0]  h_tag [NTHR];
  logic [NTHR-1:0]   h_b1, h_b2;

  logic              gnt_v;
  logic [TID_W-1:0]  gnt_idx;

  logic              v_q, v_d;
  logic [TID_W-1:0]  tid_q, tid_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [PREG_W-1:0] ps1_q, ps1_d, ps2_q, ps2_d, pd_q, pd_d;
  logic              b1_q, b1_d, b2_q, b2_d;

  function automatic logic usable(input logic [NPREG-1:0] r, input logic wv,
                                  input logic [PREG_W-1:0] wi,
                                  input logic [PREG_W-1:0] p);
    return r[p] || (wv && (wi == p));
  endfunction

  for (genvar t = 0; t < int'(NTHR); t++) begin : g_thr
    localparam logic [TID_W-1:0] TV = TID_W'(t);

    assign push[t]     = in_valid && (in_tid == TV) && in_ready[t];
    assign pop[t]      = gnt_v && (gnt_idx == TV);

    isq_thread_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push[t]),
      .wr_data  ({in_tag, in_dst, in_src2, in_src1}),
      .pop      (pop[t]),
      .rd_data  (head_ent[t]),
      .not_empty(head_v[t]),
      .has_room (in_ready[t])
    );

    assign h_ps1[t] = {TV, head_ent[t][AREG_W-1:0]};
    assign h_ps2[t] = {TV, head_ent[t][2*AREG_W-1:AREG_W]};
    assign h_pd[t]  = {TV, head_ent[t][3*AREG_W-1:2*AREG_W]};
    assign h_tag[t] = head_ent[t][ENT_W-1:3*AREG_W];

    assign h_b1[t]  = !rdy[h_ps1[t]] && wb_v && (wb_i == h_ps1[t]);
    assign h_b2[t]  = !rdy[h_ps2[t]] && wb_v && (wb_i == h_ps2[t]);

    assign elig[t]  = head_v[t]
                   && usable(rdy, wb_v, wb_i, h_ps1[t])
                   && usable(rdy, wb_v, wb_i, h_ps2[t])
                   && usable(rdy, wb_v, wb_i, h_pd[t]);
  end

  isq_rr_pick #(.N(NTHR), .IDX_W(TID_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (elig),
    .gnt_v  (gnt_v),
    .gnt_idx(gnt_idx)
  );

  isq_ready_board #(.NPREG(NPREG), .PREG_W(PREG_W), .WB_LAT(WB_LAT)) u_board (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (gnt_v),
    .clr_idx (h_pd[gnt_idx]),
    .res_v   (v_q),
    .res_idx (pd_q),
    .rdy     (rdy),
    .wb_valid(wb_v),
    .wb_idx  (wb_i)
  );

  always_comb begin
    v_d   = gnt_v;
    tid_d = gnt_idx;
    tag_d = h_tag[gnt_idx];
    ps1_d = h_ps1[gnt_idx];
    ps2_d = h_ps2[gnt_idx];
    pd_d  = h_pd[gnt_idx];
    b1_d  = gnt_v && h_b1[gnt_idx];
    b2_d  = gnt_v && h_b2[gnt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      tid_q <= '0;
      tag_q <= '0;
      ps1_q <= '0;
      ps2_q <= '0;
      pd_q  <= '0;
      b1_q  <= 1'b0;
      b2_q  <= 1'b0;
    end else begin
      v_q <= v_d;
      b1_q <= b1_d;
      b2_q <= b2_d;
      if (gnt_v) begin
        tid_q <= tid_d;
        tag_q <= tag_d;
        ps1_q <= ps1_d;
        ps2_q <= ps2_d;
        pd_q  <= pd_d;
      end
    end
  end

  assign iss_valid = v_q;
  assign iss_tid   = tid_q;
  assign iss_tag   = tag_q;
  assign iss_psrc1 = ps1_q;
  assign iss_psrc2 = ps2_q;
  assign iss_pdst  = pd_q;
  assign iss_byp1  = b1_q;
  assign iss_byp2  = b2_q;
  assign wb_valid  = wb_v;
  assign wb_pdst   = wb_i;
endmodule

// File: rtl/smt_inorder_sched_chk.sv
module smt_inorder_sched_chk #(
  parameter int unsigned NTHR  = 8,
  parameter int unsigned NAREG = 16,
  parameter int unsigned DEPTH = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  in_valid,
  input logic [$clog2(NTHR)-1:0]               in_tid,
  input logic [NTHR-1:0]                       in_ready,
  input logic                                  iss_valid,
  input logic [$clog2(NTHR)-1:0]               iss_tid,
  input logic [$clog2(NTHR)+$clog2(NAREG)-1:0] iss_psrc1,
  input logic [$clog2(NTHR)+$clog2(NAREG)-1:0] iss_psrc2,
  input logic [$clog2(NTHR)+$clog2(NAREG)-1:0] iss_pdst,
  input logic                                  iss_byp1,
  input logic                                  iss_byp2,
  input logic                                  wb_valid,
  input logic [$clog2(NTHR)+$clog2(NAREG)-1:0] wb_pdst
);
  localparam int unsigned TID_W = $clog2(NTHR);
  localparam int unsigned NPREG = NTHR * NAREG;
  localparam int unsigned CNT_W = $clog2(DEPTH + 2);

  logic [NPREG-1:0] pend;
  logic [CNT_W-1:0] occ [NTHR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int t = 0; t < int'(NTHR); t++) occ[t] <= '0;
    end else begin
      if (wb_valid)  pend[wb_pdst] <= 1'b0;
      if (iss_valid) pend[iss_pdst] <= 1'b1;
      for (int t = 0; t < int'(NTHR); t++) begin
        if ((in_valid && in_ready[in_tid] && (in_tid == TID_W'(t)))
            && !(iss_valid && (iss_tid == TID_W'(t))))
          occ[t] <= occ[t] + CNT_W'(1);
        else if (!(in_valid && in_ready[in_tid] && (in_tid == TID_W'(t)))
                 && (iss_valid && (iss_tid == TID_W'(t))))
          occ[t] <= occ[t] - CNT_W'(1);
      end
    end
  end

  AST_SRC_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (!pend[iss_psrc1] && !pend[iss_psrc2])); // R5

  AST_WB_HAS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> pend[wb_pdst]); // R6

  AST_ISSUE_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (occ[iss_tid] != '0)); // R3

  AST_BYP1_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_byp1) |-> ($past(wb_valid) && ($past(wb_pdst) == iss_psrc1))); // R7

  AST_BYP2_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_byp2) |-> ($past(wb_valid) && ($past(wb_pdst) == iss_psrc2))); // R7

  for (genvar t = 0; t < int'(NTHR); t++) begin : g_full
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      ((occ[t] == CNT_W'(DEPTH)) && !(iss_valid && (iss_tid == TID_W'(t))))
        |-> !in_ready[t]); // R2
  end
endmodule

bind smt_inorder_sched smt_inorder_sched_chk #(
  .NTHR(NTHR), .NAREG(NAREG), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
  .in_ready(in_ready), .iss_valid(iss_valid), .iss_tid(iss_tid),
  .iss_psrc1(iss_psrc1), .iss_psrc2(iss_psrc2), .iss_pdst(iss_pdst),
  .iss_byp1(iss_byp1), .iss_byp2(iss_byp2), .wb_valid(wb_valid),
  .wb_pdst(wb_pdst)
);

// File: tb/smt_inorder_sched_test.sv
module smt_inorder_sched_test;
  localparam int WB_LAT = 3;
  localparam int DEPTH  = 4;
  localparam int NV     = 16;
  // {0, tid[2:0], src1[3:0], src2[3:0], dst[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'h0123, 16'h0334, 16'h1011, 16'h1112, 16'h7AAA, 16'h7A0B, 16'h3FE1, 16'h0441,
    16'h2222, 16'h5123, 16'h2232, 16'h6789, 16'h6977, 16'h1228, 16'h4000, 16'h0148};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_tid = '0;
  logic [3:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [7:0] in_tag = '0;
  logic [7:0] in_ready;
  logic iss_valid, iss_byp1, iss_byp2, wb_valid;
  logic [2:0] iss_tid;
  logic [7:0] iss_tag;
  logic [6:0] iss_psrc1, iss_psrc2, iss_pdst, wb_pdst;

  always #10 clk = ~clk;

  smt_inorder_sched uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_tag(in_tag),
    .in_ready(in_ready), .iss_valid(iss_valid), .iss_tid(iss_tid),
    .iss_tag(iss_tag), .iss_psrc1(iss_psrc1), .iss_psrc2(iss_psrc2),
    .iss_pdst(iss_pdst), .iss_byp1(iss_byp1), .iss_byp2(iss_byp2),
    .wb_valid(wb_valid), .wb_pdst(wb_pdst));

  int n_tests = 0, n_fail = 0, cyc = 0;
  int seqn [8];
  int next_exp [8];
  logic [3:0] a_s1 [8][256];
  logic [3:0] a_s2 [8][256];
  logic [3:0] a_d  [8][256];
  int iss_cyc [8][256];
  logic iss_b1 [8][256];
  logic iss_b2 [8][256];
  int earliest [128];
  logic wbe_v [32];
  logic [6:0] wbe_p [32];
  int ord_tid [1024];
  int ord_tag [1024];
  int ord_n = 0;
  int acc_cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // continuous monitor of the issue and writeback ports
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wb_valid == wbe_v[cyc % 32], "R6 wb_valid timing", int'(wb_valid), int'(wbe_v[cyc % 32]));
      if (wbe_v[cyc % 32])
        chk(wb_pdst == wbe_p[cyc % 32], "R6 wb_pdst", int'(wb_pdst), int'(wbe_p[cyc % 32]));
      wbe_v[cyc % 32] = 1'b0;
      if (iss_valid) begin
        chk(int'(iss_tag) == next_exp[iss_tid], "R3 per-thread order", int'(iss_tag), next_exp[iss_tid]);
        chk(iss_psrc1 == {iss_tid, a_s1[iss_tid][iss_tag]}, "R4 psrc1 join", int'(iss_psrc1),
            int'({iss_tid, a_s1[iss_tid][iss_tag]}));
        chk(iss_psrc2 == {iss_tid, a_s2[iss_tid][iss_tag]}, "R4 psrc2 join", int'(iss_psrc2),
            int'({iss_tid, a_s2[iss_tid][iss_tag]}));
        chk(iss_pdst == {iss_tid, a_d[iss_tid][iss_tag]}, "R4 pdst join", int'(iss_pdst),
            int'({iss_tid, a_d[iss_tid][iss_tag]}));
        chk(cyc >= earliest[iss_psrc1] && cyc >= earliest[iss_psrc2], "R5 source pending",
            cyc, (earliest[iss_psrc1] > earliest[iss_psrc2]) ? earliest[iss_psrc1] : earliest[iss_psrc2]);
        chk(cyc >= earliest[iss_pdst], "R9 destination pending", cyc, earliest[iss_pdst]);
        next_exp[iss_tid] = int'(iss_tag) + 1;
        iss_cyc[iss_tid][iss_tag] = cyc;
        iss_b1[iss_tid][iss_tag] = iss_byp1;
        iss_b2[iss_tid][iss_tag] = iss_byp2;
        earliest[iss_pdst] = cyc + WB_LAT + 1;
        wbe_v[(cyc + WB_LAT) % 32] = 1'b1;
        wbe_p[(cyc + WB_LAT) % 32] = iss_pdst;
        ord_tid[ord_n] = int'(iss_tid);
        ord_tag[ord_n] = int'(iss_tag);
        ord_n++;
      end
    end
  end

  task automatic push(input int t, input logic [3:0] s1, input logic [3:0] s2, input logic [3:0] d);
    @(negedge clk);
    while (!in_ready[t]) @(negedge clk);
    a_s1[t][seqn[t]] = s1;
    a_s2[t][seqn[t]] = s2;
    a_d[t][seqn[t]]  = d;
    in_valid = 1'b1;
    in_tid   = 3'(t);
    in_src1  = s1;
    in_src2  = s2;
    in_dst   = d;
    in_tag   = 8'(seqn[t]);
    acc_cyc  = cyc;
    seqn[t]++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    int n, p2, p5, tg6;
    for (int t = 0; t < 8; t++) begin seqn[t] = 0; next_exp[t] = 0; end
    for (int i = 0; i < 128; i++) earliest[i] = 0;
    for (int i = 0; i < 32; i++) begin wbe_v[i] = 1'b0; wbe_p[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs and full acceptance after reset
    chk(iss_valid == 1'b0, "R1 iss_valid reset", int'(iss_valid), 0);
    chk(wb_valid == 1'b0, "R1 wb_valid reset", int'(wb_valid), 0);
    chk(in_ready == 8'hFF, "R1 in_ready reset", int'(in_ready), 255);

    // table of mixed instructions, checked by the monitor
    for (int v = 0; v < NV; v++)
      push(int'(VEC[v][14:12]), VEC[v][11:8], VEC[v][7:4], VEC[v][3:0]);
    drain();
    for (int t = 0; t < 8; t++)
      chk(next_exp[t] == seqn[t], "R3 all issued", next_exp[t], seqn[t]);

    // R10: lone independent instruction
    n = seqn[3];
    push(3, 4'h1, 4'h2, 4'h6);
    drain();
    chk(iss_cyc[3][n] == acc_cyc + 2, "R10 insert-to-issue", iss_cyc[3][n], acc_cyc + 2);

    // R7/R8: two producers, two consumers, one younger independent op
    n  = ord_n;
    p2 = seqn[2];
    p5 = seqn[5];
    push(2, 4'h0, 4'h0, 4'h3);
    push(5, 4'h0, 4'h0, 4'h3);
    push(2, 4'h3, 4'h0, 4'h5);
    push(2, 4'h8, 4'h9, 4'h4);
    push(5, 4'h3, 4'h3, 4'h5);
    drain();
    chk(ord_tid[n+2] == 2 && ord_tag[n+2] == p2 + 1, "R8 third issue", ord_tid[n+2], 2);
    chk(ord_tid[n+3] == 5 && ord_tag[n+3] == p5 + 1, "R8 rotation picks thread 5", ord_tid[n+3], 5);
    chk(ord_tid[n+4] == 2 && ord_tag[n+4] == p2 + 2, "R8 younger op last", ord_tid[n+4], 2);
    chk(iss_cyc[2][p2+1] - iss_cyc[2][p2] == WB_LAT + 1, "R7 dependent distance",
        iss_cyc[2][p2+1] - iss_cyc[2][p2], WB_LAT + 1);
    chk(iss_b1[2][p2+1] == 1'b1, "R7 bypass flag src1", int'(iss_b1[2][p2+1]), 1);
    chk(iss_b1[5][p5+1] == 1'b1 && iss_b2[5][p5+1] == 1'b1, "R7 bypass flags both",
        int'({iss_b1[5][p5+1], iss_b2[5][p5+1]}), 3);

    // R9: write-after-write wait
    tg6 = seqn[6];
    push(6, 4'h0, 4'h0, 4'h9);
    push(6, 4'h0, 4'h1, 4'h9);
    drain();
    chk(iss_cyc[6][tg6+1] - iss_cyc[6][tg6] == WB_LAT + 1, "R9 WAW distance",
        iss_cyc[6][tg6+1] - iss_cyc[6][tg6], WB_LAT + 1);
    chk(iss_b1[6][tg6+1] == 1'b0 && iss_b2[6][tg6+1] == 1'b0, "R9 no bypass flag",
        int'({iss_b1[6][tg6+1], iss_b2[6][tg6+1]}), 0);

    // R2: fill thread 4 with a self-dependent chain
    for (int k = 0; k < DEPTH + 1; k++) push(4, 4'h7, 4'h7, 4'h7);
    @(negedge clk);
    chk(in_ready[4] == 1'b0, "R2 full thread blocks", int'(in_ready[4]), 0);
    chk(in_ready[3] == 1'b1 && in_ready[0] == 1'b1, "R2 other threads open",
        int'({in_ready[3], in_ready[0]}), 3);
    n = seqn[3];
    push(3, 4'h2, 4'h2, 4'hC);
    repeat (3) @(negedge clk);
    chk(iss_cyc[3][n] == acc_cyc + 2, "R2 other thread issues while full", iss_cyc[3][n], acc_cyc + 2);
    repeat (60) @(negedge clk);
    chk(next_exp[4] == seqn[4], "R3 chain drained", next_exp[4], seqn[4]);
    chk(in_ready == 8'hFF, "R2 room restored", int'(in_ready), 255);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule